// File: doc/BRIEF.md
# Interrupt Priority Level Resolver

This block turns a set of pending interrupt sources into a single requested priority level and decides whether that level should interrupt the processor. It holds two registers: a software request register, where software sets bits to post requests, and a current priority level register. It also samples an external interrupt status vector directly. Software request bits map to small levels counted up from the lowest software bit. External lines use their own bit index as their level, so any pending external line overrides the software level.

An evaluation takes place only while the block is armed. A return-from-exception strobe arms it, and reset also arms it. The armed evaluation always disarms the block. If the resolved level is nonzero and strictly above the current priority level, the evaluation pulses a trap request. It also captures two values: a summary word with every pending source at its own bit position, and the winning level as an interrupt ID. If no trap is taken, both captured values keep their old contents.

Top module: `irq_level_resolver`

## Requirements
- R1: The software request register keeps only bits 4 through 18 of a write (mask 0x7fff0). Every other bit reads back as zero on `sw_req_o`.
- R2: The current priority level register keeps only the low 5 bits of a write, which read back on `ipl_o`.
- R3: With no external line pending, the resolved level is the index of the highest set software bit minus 3. Bit 4 gives level 1, bit 9 gives level 6 and bit 18 gives level 15.
- R4: When any external bit in 20 through 23 is set, the resolved level is the highest such bit index, whatever software bits are set.
- R5: The captured summary is the OR of the software register and the external bits 20 through 23, each at its own position. External bits outside 20 through 23 have no effect on the level or on the summary.
- R6: A trap is taken only when the resolved level is nonzero and strictly greater than the current priority level. An equal level, or level zero, takes no trap.
- R7: On a trap, `trap_o` is high for the cycle after the evaluating edge, and `summary_o` and `intid_o` show the captured values in that same cycle. With no trap, `summary_o` and `intid_o` hold their previous values.
- R8: An evaluation happens at each clock edge where the block is armed, and that edge disarms it. A cycle with `rearm_i` high arms it for the next edge. A rearm that coincides with an evaluation leaves the block armed. Pending sources are not looked at while the block is disarmed.
- R9: An evaluation uses the register contents from before any write landing at the same edge.
- R10: After reset, `trap_o`, `summary_o`, `intid_o`, `sw_req_o` and `ipl_o` are all zero, and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_i | input | 1 | Write strobe for the software request register |
| sw_wdata_i | input | 32 | Write data for the software request register |
| ipl_wr_i | input | 1 | Write strobe for the current priority level |
| ipl_wdata_i | input | 32 | Write data for the current priority level |
| ext_irq_i | input | 32 | External interrupt status vector |
| rearm_i | input | 1 | Return-from-exception strobe that arms an evaluation |
| trap_o | output | 1 | Trap request pulse |
| summary_o | output | 32 | Captured summary of pending sources |
| intid_o | output | 5 | Captured interrupt ID (winning level) |
| sw_req_o | output | 32 | Software request register contents |
| ipl_o | output | 5 | Current priority level register contents |

## Verification
Two events can fall on the same edge and need separate handling.

The first is a rearm arriving on the very edge where an armed evaluation clears the arm flag. The bench holds `rearm_i` high for two cycles with nothing pending. It then raises an external line after the second edge. A trap with ID 20 on the following edge shows that the flag survived. Losing the flag would give no trap.

The second is a register write landing on the evaluating edge. The bench writes a software bit in exactly that cycle. It expects no trap, because the evaluation uses the old register value. It then expects a trap with ID 1 once the block is rearmed.

// File: rtl/irq_res_pkg.sv
// Package: shared types and helpers for the interrupt priority level resolver.
// Assumes bit ranges never exceed 64 positions.
package irq_res_pkg;

    // How a priority encoder maps a winning bit index to a level
    typedef enum logic [0:0] {
        MAP_OFFSET = 1'b0,  // level = index - low bound + 1
        MAP_DIRECT = 1'b1   // level = index
    } lvl_map_e;

    // Build a contiguous mask covering bit positions lo..hi inclusive
    function automatic logic [63:0] span_mask(input int lo, input int hi);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_lvl_encoder.sv
// Module: highest-set-bit encoder over one bit range of a source vector.
// Produces a level for the highest set bit in LO..HI, mapped either with an
// offset (software style) or directly (external style). Assumes HI < VEC_W
// and that every mapped level fits in LVL_W bits.
module irq_lvl_encoder
    import irq_res_pkg::*;
#(
    parameter int       VEC_W = 32,
    parameter int       LVL_W = 5,
    parameter int       LO    = 4,
    parameter int       HI    = 18,
    parameter lvl_map_e MODE  = MAP_OFFSET
) (
    input  logic [VEC_W-1:0] vec_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic             valid_o
);

    localparam int SPAN = HI - LO + 1;

    // Any bit pending in range
    always_comb valid_o = |vec_i[HI:LO];

    generate
        if (MODE == MAP_OFFSET) begin : g_offset
            // Scan upward; the highest set bit overwrites earlier winners
            always_comb begin
                lvl_o = '0;
                for (int i = 0; i < SPAN; i++) begin
                    if (vec_i[LO + i]) lvl_o = LVL_W'(i + 1);
                end
            end
        end else begin : g_direct
            // Scan upward; the highest set bit index is the level
            always_comb begin
                lvl_o = '0;
                for (int i = 0; i < SPAN; i++) begin
                    if (vec_i[LO + i]) lvl_o = LVL_W'(LO + i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_cfg_regs.sv
// Module: software request register and current priority level register.
// Writes are masked to the implemented bits; assumes LVL_W <= VEC_W.
module irq_cfg_regs #(
    parameter int         VEC_W   = 32,
    parameter int         LVL_W   = 5,
    parameter logic [VEC_W-1:0] SW_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_i,
    input  logic [VEC_W-1:0] sw_wdata_i,
    input  logic             ipl_wr_i,
    input  logic [VEC_W-1:0] ipl_wdata_i,
    output logic [VEC_W-1:0] sw_req_o,
    output logic [LVL_W-1:0] ipl_o
);

    logic [VEC_W-1:0] sw_req_q;
    logic [LVL_W-1:0] ipl_q;

    // Software request register: keep only implemented request bits
    always_ff @(posedge clk) begin
        if (!rst_n)       sw_req_q <= '0;
        else if (sw_wr_i) sw_req_q <= sw_wdata_i & SW_MASK;
    end

    // Current priority level: keep only the low level bits
    always_ff @(posedge clk) begin
        if (!rst_n)        ipl_q <= '0;
        else if (ipl_wr_i) ipl_q <= ipl_wdata_i[LVL_W-1:0];
    end

    assign sw_req_o = sw_req_q;
    assign ipl_o    = ipl_q;

    // R1
    sw_unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req_q & ~SW_MASK) == '0);

    // R1
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_i |=> $stable(sw_req_q));

    // R2
    ipl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ipl_wr_i |=> $stable(ipl_q));

endmodule

// File: rtl/irq_trap_arb.sv
// Module: arm flag, level comparison and capture of summary and ID on a trap.
// Assumes lvl_i and summ_i are already resolved for the current cycle.
module irq_trap_arb #(
    parameter int VEC_W = 32,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rearm_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [VEC_W-1:0] summ_i,
    input  logic [LVL_W-1:0] ipl_i,
    output logic             trap_o,
    output logic [VEC_W-1:0] summary_o,
    output logic [LVL_W-1:0] intid_o
);

    logic             armed_q;
    logic             take;
    logic             trap_q;
    logic [VEC_W-1:0] summary_q;
    logic [LVL_W-1:0] intid_q;

    // Trap decision: armed, nonzero level, strictly above current level
    always_comb take = armed_q && (lvl_i != '0) && (lvl_i > ipl_i);

    // Arm flag: rearm wins; an armed evaluation otherwise clears it
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b1;
        else if (rearm_i) armed_q <= 1'b1;
        else if (armed_q) armed_q <= 1'b0;
    end

    // Trap pulse, one cycle per taken evaluation
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= take;
    end

    // Summary and ID capture, held when no trap is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            summary_q <= '0;
            intid_q   <= '0;
        end else if (take) begin
            summary_q <= summ_i;
            intid_q   <= lvl_i;
        end
    end

    assign trap_o    = trap_q;
    assign summary_o = summary_q;
    assign intid_o   = intid_q;

    // R8
    armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !rearm_i |=> !armed_q);

    // R8
    trap_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> $past(armed_q));

    // R6
    trap_above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (intid_q != '0) && (intid_q > $past(ipl_i)));

    // R7
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_q |-> $stable(intid_q) && $stable(summary_q));

endmodule

// File: rtl/irq_level_resolver.sv
// Module: top of the interrupt priority level resolver.
// Resolves software and external sources to one level, gates it by the arm
// flag and current level, and captures summary and ID on a trap. Assumes
// software range below external range and all levels fit in LVL_W bits.
module irq_level_resolver
    import irq_res_pkg::*;
#(
    parameter int VEC_W  = 32,
    parameter int LVL_W  = 5,
    parameter int SW_LO  = 4,
    parameter int SW_HI  = 18,
    parameter int EXT_LO = 20,
    parameter int EXT_HI = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_i,
    input  logic [VEC_W-1:0] sw_wdata_i,
    input  logic             ipl_wr_i,
    input  logic [VEC_W-1:0] ipl_wdata_i,
    input  logic [VEC_W-1:0] ext_irq_i,
    input  logic             rearm_i,
    output logic             trap_o,
    output logic [VEC_W-1:0] summary_o,
    output logic [LVL_W-1:0] intid_o,
    output logic [VEC_W-1:0] sw_req_o,
    output logic [LVL_W-1:0] ipl_o
);

    localparam logic [VEC_W-1:0] SW_MASK  = VEC_W'(span_mask(SW_LO, SW_HI));
    localparam logic [VEC_W-1:0] EXT_MASK = VEC_W'(span_mask(EXT_LO, EXT_HI));
    localparam int               SW_TOP   = SW_HI - SW_LO + 1;

    logic [VEC_W-1:0] sw_req;
    logic [LVL_W-1:0] ipl;
    logic [VEC_W-1:0] ext_sel;
    logic [LVL_W-1:0] sw_lvl;
    logic [LVL_W-1:0] ext_lvl;
    logic             sw_valid;
    logic             ext_valid;
    logic [LVL_W-1:0] res_lvl;
    logic [VEC_W-1:0] res_summ;

    irq_cfg_regs #(
        .VEC_W   (VEC_W),
        .LVL_W   (LVL_W),
        .SW_MASK (SW_MASK)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_wr_i     (sw_wr_i),
        .sw_wdata_i  (sw_wdata_i),
        .ipl_wr_i    (ipl_wr_i),
        .ipl_wdata_i (ipl_wdata_i),
        .sw_req_o    (sw_req),
        .ipl_o       (ipl)
    );

    // External lines outside their range take no part
    always_comb ext_sel = ext_irq_i & EXT_MASK;

    irq_lvl_encoder #(
        .VEC_W (VEC_W),
        .LVL_W (LVL_W),
        .LO    (SW_LO),
        .HI    (SW_HI),
        .MODE  (MAP_OFFSET)
    ) u_sw_enc (
        .vec_i   (sw_req),
        .lvl_o   (sw_lvl),
        .valid_o (sw_valid)
    );

    irq_lvl_encoder #(
        .VEC_W (VEC_W),
        .LVL_W (LVL_W),
        .LO    (EXT_LO),
        .HI    (EXT_HI),
        .MODE  (MAP_DIRECT)
    ) u_ext_enc (
        .vec_i   (ext_sel),
        .lvl_o   (ext_lvl),
        .valid_o (ext_valid)
    );

    // Level selection: any external request overrides the software level
    always_comb res_lvl = ext_valid ? ext_lvl : sw_lvl;

    // Summary of every pending source at its own position
    always_comb res_summ = sw_req | ext_sel;

    irq_trap_arb #(
        .VEC_W (VEC_W),
        .LVL_W (LVL_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rearm_i   (rearm_i),
        .lvl_i     (res_lvl),
        .summ_i    (res_summ),
        .ipl_i     (ipl),
        .trap_o    (trap_o),
        .summary_o (summary_o),
        .intid_o   (intid_o)
    );

    assign sw_req_o = sw_req;
    assign ipl_o    = ipl;

    // R3
    sw_level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_valid |-> (sw_lvl >= LVL_W'(1)) && (sw_lvl <= LVL_W'(SW_TOP)));

    // R4
    ext_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> (res_lvl >= LVL_W'(EXT_LO)) && (res_lvl <= LVL_W'(EXT_HI)));

endmodule

// File: tb/sim_irq_level_resolver.sv
`timescale 1ns/1ps
module sim_irq_level_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_i = 1'b0;
    logic [31:0] sw_wdata_i = '0;
    logic        ipl_wr_i = 1'b0;
    logic [31:0] ipl_wdata_i = '0;
    logic [31:0] ext_irq_i = '0;
    logic        rearm_i = 1'b0;
    logic        trap_o;
    logic [31:0] summary_o;
    logic [4:0]  intid_o;
    logic [31:0] sw_req_o;
    logic [4:0]  ipl_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_level_resolver u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_wr_i     (sw_wr_i),
        .sw_wdata_i  (sw_wdata_i),
        .ipl_wr_i    (ipl_wr_i),
        .ipl_wdata_i (ipl_wdata_i),
        .ext_irq_i   (ext_irq_i),
        .rearm_i     (rearm_i),
        .trap_o      (trap_o),
        .summary_o   (summary_o),
        .intid_o     (intid_o),
        .sw_req_o    (sw_req_o),
        .ipl_o       (ipl_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic write_sw(input logic [31:0] v);
        @(negedge clk); sw_wr_i = 1'b1; sw_wdata_i = v;
        @(negedge clk); sw_wr_i = 1'b0;
    endtask

    task automatic write_ipl(input logic [31:0] v);
        @(negedge clk); ipl_wr_i = 1'b1; ipl_wdata_i = v;
        @(negedge clk); ipl_wr_i = 1'b0;
    endtask

    // Pulse rearm one cycle; the next edge arms, the one after evaluates
    task automatic rearm_eval(input string req, input logic exp_trap,
                              input logic [31:0] exp_summ, input logic [4:0] exp_id);
        @(negedge clk); rearm_i = 1'b1;
        @(negedge clk); rearm_i = 1'b0;
        @(negedge clk);
        check(req, "trap", {31'b0, trap_o}, {31'b0, exp_trap});
        check(req, "summary", summary_o, exp_summ);
        check(req, "intid", {27'b0, intid_o}, {27'b0, exp_id});
        @(negedge clk);
        check(req, "trap after evaluation", {31'b0, trap_o}, 32'h0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R10 reset values
        check("R10", "trap", {31'b0, trap_o}, 32'h0);
        check("R10", "summary", summary_o, 32'h0);
        check("R10", "intid", {27'b0, intid_o}, 32'h0);
        check("R10", "sw_req", sw_req_o, 32'h0);
        check("R10", "ipl", {27'b0, ipl_o}, 32'h0);
    endtask

    task automatic t_masks();
        write_sw(32'hFFFF_FFFF);
        check("R1", "sw mask", sw_req_o, 32'h0007_FFF0);
        write_ipl(32'hFFFF_FFE3);
        check("R2", "ipl low bits", {27'b0, ipl_o}, 32'h3);
        write_ipl(32'h0);
        // R8 disarmed: pending software bits are not looked at
        repeat (3) @(negedge clk);
        check("R8", "no trap while disarmed", {31'b0, trap_o}, 32'h0);
        check("R8", "id untouched while disarmed", {27'b0, intid_o}, 32'h0);
    endtask

    task automatic t_sw_levels();
        write_sw(32'h0000_0010);
        rearm_eval("R3", 1'b1, 32'h0000_0010, 5'd1);
        write_sw(32'h0004_0000);
        rearm_eval("R3", 1'b1, 32'h0004_0000, 5'd15);
        write_sw(32'h0000_0210);
        rearm_eval("R3", 1'b1, 32'h0000_0210, 5'd6);
    endtask

    task automatic t_ext();
        write_sw(32'h0004_0010);
        ext_irq_i = 32'h0020_0000;
        rearm_eval("R4", 1'b1, 32'h0024_0010, 5'd21);
        // R5 bits 2 and 30 outside the external range are ignored
        ext_irq_i = 32'h4090_0004;
        rearm_eval("R5", 1'b1, 32'h0094_0010, 5'd23);
        ext_irq_i = 32'h4000_0004;
        rearm_eval("R5", 1'b1, 32'h0004_0010, 5'd15);
        ext_irq_i = '0;
    endtask

    task automatic t_threshold();
        write_sw(32'h0000_0010);
        ext_irq_i = 32'h0090_0000;
        rearm_eval("R4", 1'b1, 32'h0090_0010, 5'd23);
        ext_irq_i = '0;
        write_sw(32'h0004_0000);
        write_ipl(32'd15);
        // R6 equal level takes no trap; R7 capture holds
        rearm_eval("R6", 1'b0, 32'h0090_0010, 5'd23);
        write_ipl(32'd14);
        rearm_eval("R6", 1'b1, 32'h0004_0000, 5'd15);
        write_ipl(32'd31);
        ext_irq_i = 32'h0080_0000;
        rearm_eval("R7", 1'b0, 32'h0004_0000, 5'd15);
        ext_irq_i = '0;
        write_sw(32'h0);
        write_ipl(32'd0);
        rearm_eval("R6", 1'b0, 32'h0004_0000, 5'd15);
    endtask

    task automatic t_single_eval();
        ext_irq_i = 32'h0040_0000;
        repeat (3) @(negedge clk);
        check("R8", "disarmed ignores external", {31'b0, trap_o}, 32'h0);
        check("R8", "disarmed id hold", {27'b0, intid_o}, 32'd15);
        rearm_eval("R8", 1'b1, 32'h0040_0000, 5'd22);
        repeat (2) @(negedge clk);
        check("R8", "one evaluation per arm", {31'b0, trap_o}, 32'h0);
        ext_irq_i = '0;
    endtask

    task automatic t_write_collision();
        @(negedge clk); rearm_i = 1'b1;
        @(negedge clk); rearm_i = 1'b0; sw_wr_i = 1'b1; sw_wdata_i = 32'h10;
        @(negedge clk); sw_wr_i = 1'b0;
        check("R9", "evaluation sees old register", {31'b0, trap_o}, 32'h0);
        check("R9", "write landed", sw_req_o, 32'h10);
        check("R9", "id unchanged", {27'b0, intid_o}, 32'd22);
        rearm_eval("R9", 1'b1, 32'h0000_0010, 5'd1);
        write_sw(32'h0);
    endtask

    task automatic t_rearm_collision();
        write_ipl(32'd5);
        @(negedge clk); rearm_i = 1'b1;
        @(negedge clk);
        @(negedge clk); rearm_i = 1'b0; ext_irq_i = 32'h0010_0000;
        @(negedge clk);
        check("R8", "rearm on evaluating edge keeps arm", {31'b0, trap_o}, 32'h1);
        check("R8", "id after kept arm", {27'b0, intid_o}, 32'd20);
        check("R5", "summary after kept arm", summary_o, 32'h0010_0000);
        ext_irq_i = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_sw_levels();
        t_ext();
        t_threshold();
        t_single_eval();
        t_write_collision();
        t_rearm_collision();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule